// File: doc/BRIEF.md
# Inter-Cluster Write Destination Decoder

This block sits at the write stage of a four-issue core whose register file is split into four clusters. Each issue slot carries a wide source operand address, a narrow second source address, a three-bit destination cluster code and a destination register index. The upper field of the wide source names the slot's home cluster. The narrow source always refers to the same cluster, so both operand reads stay local. The destination code is read against that home cluster. It can name one cluster directly, name the home cluster together with a second cluster a fixed distance away, or name all four.

The block expands every code into a one-hot cluster mask and holds back any younger slot whose write would collide with an older one. It then moves accepted results across a crossbar into per-cluster write lanes. A write into the home cluster reaches its lane one clock after acceptance. A write into any other cluster takes one extra clock to cross the chip. Each cluster offers one lane per issue slot.

Top module: `cluster_write_router`

## Requirements
- R1: For each slot, `rd_cluster` equals the top two bits of the wide source, `rd_idx_a` equals its low four bits, and `rd_idx_b` equals the narrow source. All three are combinational.
- R2: Codes 000 to 011 give a mask with only bit N set, where N is the code value. Mask bit c stands for cluster c, and slot s uses `dst_mask[s*4 +: 4]`.
- R3: Codes 100, 101 and 110 give a mask with the home cluster x set and cluster (x+k) mod 4 set, where k is 1, 2 or 3 in that order.
- R4: Code 111 gives the mask 1111.
- R5: A slot with its valid bit low has a zero mask, never stalls and produces no write, whatever its other fields hold.
- R6: A valid slot stalls when an older valid slot in the same cycle shares a cluster in its mask and has the same destination register. The older slot does not stall, and slots that only share a cluster but target different registers do not stall.
- R7: An accepted slot (valid and not stalled) that writes its home cluster c raises `wr_en[c*4+s]` one clock later. The lane carries the destination register on `wr_idx` and the result on `wr_data`.
- R8: For each non-home cluster c in the mask of an accepted slot, `wr_en[c*4+s]` is raised two clocks after acceptance and is low one clock after acceptance.
- R9: A valid slot stalls when its home-cluster write would land in the same clock as a remote write accepted in the previous cycle to that cluster, if that remote write comes from the same slot or targets the same register.
- R10: A stalled slot produces no write on any lane.
- R11: After reset, all write enables, stalls and masks are zero while no slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_vld | input | 4 | Slot carries an instruction |
| slot_full_src | input | 24 | Wide source per slot: cluster in bits 5:4, register in 3:0 |
| slot_part_src | input | 16 | Narrow source register per slot |
| slot_dcode | input | 12 | Destination cluster code per slot |
| slot_dreg | input | 16 | Destination register per slot |
| slot_wdata | input | 64 | Result per slot |
| rd_cluster | output | 8 | Home cluster per slot |
| rd_idx_a | output | 16 | Local read index of the wide source |
| rd_idx_b | output | 16 | Local read index of the narrow source |
| dst_mask | output | 16 | One-hot destination cluster set per slot |
| slot_stall | output | 4 | Hold this slot this cycle |
| wr_en | output | 16 | Write enable, lane c*4+s |
| wr_idx | output | 64 | Register index per lane |
| wr_data | output | 256 | Write data per lane |

## Verification
The assertions assume that a stalled slot is presented again by the issue logic and that no slot is driven valid while the internal reset is still held. Their reset term is the synchronised reset, so input activity inside the release window is not covered. The bench drives inputs on the falling edge and only while reset is released. It leaves at least three idle cycles between scenarios, so that remote writes still in flight never reach into the next test's expected values. One scenario overlaps bundles on purpose, to exercise the hold against a pending remote write.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

  localparam int unsigned CL_N = 4;
  localparam int unsigned CL_W = 2;

  typedef enum logic [2:0] {
    DC_U0    = 3'b000,
    DC_U1    = 3'b001,
    DC_U2    = 3'b010,
    DC_U3    = 3'b011,
    DC_PAIR1 = 3'b100,
    DC_PAIR2 = 3'b101,
    DC_PAIR3 = 3'b110,
    DC_ALL   = 3'b111
  } dcode_e;

  function automatic logic [CL_N-1:0] cl_onehot(input logic [CL_W-1:0] id);
    logic [CL_N-1:0] r;
    r     = '0;
    r[id] = 1'b1;
    return r;
  endfunction

  function automatic logic [CL_N-1:0] cl_rotl(input logic [CL_N-1:0] v,
                                              input logic [CL_W-1:0] k);
    logic [2*CL_N-1:0] t;
    t = {v, v} << k;
    return t[2*CL_N-1:CL_N];
  endfunction

endpackage

// File: rtl/cwr_slot_dec.sv
module cwr_slot_dec
  import cwr_pkg::*;
#(
  parameter int unsigned REG_W = 4
) (
  input  logic                  vld,
  input  logic [CL_W+REG_W-1:0] full_src,
  input  logic [REG_W-1:0]      part_src,
  input  logic [2:0]            dcode,
  output logic [CL_W-1:0]       home_id,
  output logic [CL_N-1:0]       home_oh,
  output logic [REG_W-1:0]      idx_a,
  output logic [REG_W-1:0]      idx_b,
  output logic [CL_N-1:0]       dmask
);

  logic [CL_N-1:0] raw_mask;

  always_comb begin
    home_id = full_src[CL_W+REG_W-1 -: CL_W];
    home_oh = cl_onehot(home_id);
    idx_a   = full_src[REG_W-1:0];
    idx_b   = part_src;
  end

  always_comb begin
    case (dcode_e'(dcode))
      DC_U0, DC_U1, DC_U2, DC_U3:
        raw_mask = cl_onehot(dcode[CL_W-1:0]);
      DC_PAIR1, DC_PAIR2, DC_PAIR3:
        raw_mask = home_oh | cl_rotl(home_oh, dcode[CL_W-1:0] + 2'd1);
      default:
        raw_mask = '1;
    endcase
    dmask = vld ? raw_mask : '0;
  end

endmodule

// File: rtl/cwr_hazard.sv
module cwr_hazard
  import cwr_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned REG_W = 4
) (
  input  logic [NSLOT-1:0]            vld,
  input  logic [NSLOT-1:0][CL_N-1:0]  dmask,
  input  logic [NSLOT-1:0][CL_N-1:0]  home_oh,
  input  logic [NSLOT-1:0][REG_W-1:0] dreg,
  input  logic [NSLOT-1:0]            pend_vld,
  input  logic [NSLOT-1:0][CL_N-1:0]  pend_far,
  input  logic [NSLOT-1:0][REG_W-1:0] pend_reg,
  output logic [NSLOT-1:0]            stall
);

  logic [NSLOT-1:0] same_cycle_hit;
  logic [NSLOT-1:0] pending_hit;

  always_comb begin
    same_cycle_hit = '0;
    pending_hit    = '0;
    for (int s = 0; s < NSLOT; s++) begin
      for (int i = 0; i < s; i++) begin
        if (vld[i] && (|(dmask[i] & dmask[s])) && (dreg[i] == dreg[s]))
          same_cycle_hit[s] = 1'b1;
      end
      for (int j = 0; j < NSLOT; j++) begin
        if (pend_vld[j] && (|(pend_far[j] & dmask[s] & home_oh[s])) &&
            ((j == s) || (pend_reg[j] == dreg[s])))
          pending_hit[s] = 1'b1;
      end
    end
    stall = vld & (same_cycle_hit | pending_hit);
  end

endmodule

// File: rtl/cwr_wr_xbar.sv
module cwr_wr_xbar
  import cwr_pkg::*;
#(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned REG_W  = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES = CL_N * NSLOT
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSLOT-1:0]             acc,
  input  logic [NSLOT-1:0][CL_N-1:0]   dmask,
  input  logic [NSLOT-1:0][CL_N-1:0]   home_oh,
  input  logic [NSLOT-1:0][REG_W-1:0]  dreg,
  input  logic [NSLOT-1:0][DATA_W-1:0] wdata,
  output logic [NSLOT-1:0]             pend_vld,
  output logic [NSLOT-1:0][CL_N-1:0]   pend_far,
  output logic [NSLOT-1:0][REG_W-1:0]  pend_reg,
  output logic [LANES-1:0]             lane_en,
  output logic [LANES-1:0][REG_W-1:0]  lane_idx,
  output logic [LANES-1:0][DATA_W-1:0] lane_data
);

  // stage one: accepted bundle, home-cluster writes leave from here
  logic [NSLOT-1:0]             s1_vld_q, s1_vld_d;
  logic [NSLOT-1:0][CL_N-1:0]   s1_near_q, s1_near_d;
  logic [NSLOT-1:0][CL_N-1:0]   s1_far_q, s1_far_d;
  logic [NSLOT-1:0][REG_W-1:0]  s1_reg_q;
  logic [NSLOT-1:0][DATA_W-1:0] s1_data_q;
  // stage two: remote writes after the crossing cycle
  logic [NSLOT-1:0]             s2_vld_q, s2_vld_d;
  logic [NSLOT-1:0][CL_N-1:0]   s2_far_q, s2_far_d;
  logic [NSLOT-1:0][REG_W-1:0]  s2_reg_q;
  logic [NSLOT-1:0][DATA_W-1:0] s2_data_q;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      s1_vld_d[s]  = acc[s];
      s1_near_d[s] = acc[s] ? (dmask[s] & home_oh[s])  : '0;
      s1_far_d[s]  = acc[s] ? (dmask[s] & ~home_oh[s]) : '0;
      s2_vld_d[s]  = s1_vld_q[s] && (|s1_far_q[s]);
      s2_far_d[s]  = s1_vld_q[s] ? s1_far_q[s] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= '0;
      s1_near_q <= '0;
      s1_far_q  <= '0;
      s2_vld_q  <= '0;
      s2_far_q  <= '0;
    end else begin
      s1_vld_q  <= s1_vld_d;
      s1_near_q <= s1_near_d;
      s1_far_q  <= s1_far_d;
      s2_vld_q  <= s2_vld_d;
      s2_far_q  <= s2_far_d;
    end
  end

  // payload registers: no reset, loaded only under their enables
  for (genvar s = 0; s < NSLOT; s++) begin : g_payload
    always_ff @(posedge clk) begin
      if (acc[s]) begin
        s1_reg_q[s]  <= dreg[s];
        s1_data_q[s] <= wdata[s];
      end
      if (s1_vld_q[s]) begin
        s2_reg_q[s]  <= s1_reg_q[s];
        s2_data_q[s] <= s1_data_q[s];
      end
    end
  end

  always_comb begin
    pend_vld = s1_vld_q;
    pend_far = s1_far_q;
    pend_reg = s1_reg_q;
  end

  for (genvar c = 0; c < CL_N; c++) begin : g_cl
    for (genvar s = 0; s < NSLOT; s++) begin : g_lane
      logic near_hit;
      logic far_hit;
      always_comb begin
        near_hit = s1_vld_q[s] & s1_near_q[s][c];
        far_hit  = s2_vld_q[s] & s2_far_q[s][c];
        lane_en[c*NSLOT+s]   = near_hit | far_hit;
        lane_idx[c*NSLOT+s]  = far_hit ? s2_reg_q[s]  : s1_reg_q[s];
        lane_data[c*NSLOT+s] = far_hit ? s2_data_q[s] : s1_data_q[s];
      end
    end
  end

endmodule

// File: rtl/cluster_write_router.sv
module cluster_write_router
  import cwr_pkg::*;
#(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned REG_W  = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned FULL_W = CL_W + REG_W,
  localparam int unsigned LANES  = CL_N * NSLOT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSLOT-1:0]          slot_vld,
  input  logic [NSLOT*FULL_W-1:0]   slot_full_src,
  input  logic [NSLOT*REG_W-1:0]    slot_part_src,
  input  logic [NSLOT*3-1:0]        slot_dcode,
  input  logic [NSLOT*REG_W-1:0]    slot_dreg,
  input  logic [NSLOT*DATA_W-1:0]   slot_wdata,
  output logic [NSLOT*CL_W-1:0]     rd_cluster,
  output logic [NSLOT*REG_W-1:0]    rd_idx_a,
  output logic [NSLOT*REG_W-1:0]    rd_idx_b,
  output logic [NSLOT*CL_N-1:0]     dst_mask,
  output logic [NSLOT-1:0]          slot_stall,
  output logic [LANES-1:0]          wr_en,
  output logic [LANES*REG_W-1:0]    wr_idx,
  output logic [LANES*DATA_W-1:0]   wr_data
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NSLOT-1:0][CL_N-1:0]   mask_v;
  logic [NSLOT-1:0][CL_N-1:0]   home_v;
  logic [NSLOT-1:0][REG_W-1:0]  dreg_v;
  logic [NSLOT-1:0][DATA_W-1:0] wdata_v;
  logic [NSLOT-1:0]             pend_vld;
  logic [NSLOT-1:0][CL_N-1:0]   pend_far;
  logic [NSLOT-1:0][REG_W-1:0]  pend_reg;
  logic [NSLOT-1:0]             stall_v;
  logic [NSLOT-1:0]             acc_v;
  logic [LANES-1:0][REG_W-1:0]  lane_idx;
  logic [LANES-1:0][DATA_W-1:0] lane_data;

  assign dreg_v  = slot_dreg;
  assign wdata_v = slot_wdata;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    cwr_slot_dec #(.REG_W(REG_W)) u_dec (
      .vld      (slot_vld[s]),
      .full_src (slot_full_src[s*FULL_W +: FULL_W]),
      .part_src (slot_part_src[s*REG_W +: REG_W]),
      .dcode    (slot_dcode[s*3 +: 3]),
      .home_id  (rd_cluster[s*CL_W +: CL_W]),
      .home_oh  (home_v[s]),
      .idx_a    (rd_idx_a[s*REG_W +: REG_W]),
      .idx_b    (rd_idx_b[s*REG_W +: REG_W]),
      .dmask    (mask_v[s])
    );
  end

  cwr_hazard #(.NSLOT(NSLOT), .REG_W(REG_W)) u_haz (
    .vld      (slot_vld),
    .dmask    (mask_v),
    .home_oh  (home_v),
    .dreg     (dreg_v),
    .pend_vld (pend_vld),
    .pend_far (pend_far),
    .pend_reg (pend_reg),
    .stall    (stall_v)
  );

  assign acc_v = slot_vld & ~stall_v;

  cwr_wr_xbar #(.NSLOT(NSLOT), .REG_W(REG_W), .DATA_W(DATA_W)) u_xbar (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acc       (acc_v),
    .dmask     (mask_v),
    .home_oh   (home_v),
    .dreg      (dreg_v),
    .wdata     (wdata_v),
    .pend_vld  (pend_vld),
    .pend_far  (pend_far),
    .pend_reg  (pend_reg),
    .lane_en   (wr_en),
    .lane_idx  (lane_idx),
    .lane_data (lane_data)
  );

  assign dst_mask   = mask_v;
  assign slot_stall = stall_v;
  assign wr_idx     = lane_idx;
  assign wr_data    = lane_data;

endmodule

// File: rtl/cwr_checker.sv
module cwr_checker
  import cwr_pkg::*;
#(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned REG_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NSLOT-1:0]       slot_vld,
  input logic [NSLOT*3-1:0]     slot_dcode,
  input logic [NSLOT*REG_W-1:0] slot_dreg,
  input logic [NSLOT*CL_W-1:0]  rd_cluster,
  input logic [NSLOT*CL_N-1:0]  dst_mask,
  input logic [NSLOT-1:0]       slot_stall,
  input logic [CL_N*NSLOT-1:0]  wr_en
);

  logic [NSLOT-1:0] acc;
  assign acc = slot_vld & ~slot_stall;

  for (genvar s = 0; s < NSLOT; s++) begin : g_s
    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_vld[s] |-> (dst_mask[s*CL_N +: CL_N] == '0) && !slot_stall[s]);

    assert_unicast_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_vld[s] && !slot_dcode[s*3+2]) |-> ($countones(dst_mask[s*CL_N +: CL_N]) == 1));

    assert_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_vld[s] && slot_dcode[s*3+2] && (slot_dcode[s*3 +: 2] != 2'b11))
        |-> ($countones(dst_mask[s*CL_N +: CL_N]) == 2));

    assert_bcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_vld[s] && (slot_dcode[s*3 +: 3] == 3'b111)) |-> (dst_mask[s*CL_N +: CL_N] == '1));

    for (genvar i = 0; i < s; i++) begin : g_older
      assert_no_dup_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[i] && acc[s] && (|(dst_mask[i*CL_N +: CL_N] & dst_mask[s*CL_N +: CL_N])))
          |-> (slot_dreg[i*REG_W +: REG_W] != slot_dreg[s*REG_W +: REG_W]));
    end

    for (genvar c = 0; c < CL_N; c++) begin : g_c
      assert_near_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[s] && dst_mask[s*CL_N+c] && (rd_cluster[s*CL_W +: CL_W] == c))
          |=> wr_en[c*NSLOT+s]);

      assert_far_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[s] && dst_mask[s*CL_N+c] && (rd_cluster[s*CL_W +: CL_W] != c))
          |-> ##2 wr_en[c*NSLOT+s]);
    end
  end

endmodule

bind cluster_write_router cwr_checker #(.NSLOT(NSLOT), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .slot_vld   (slot_vld),
  .slot_dcode (slot_dcode),
  .slot_dreg  (slot_dreg),
  .rd_cluster (rd_cluster),
  .dst_mask   (dst_mask),
  .slot_stall (slot_stall),
  .wr_en      (wr_en)
);

// File: tb/cluster_write_router_tb.sv
`timescale 1ns/1ps
module cluster_write_router_tb;

  localparam int N  = 4;
  localparam int RW = 4;
  localparam int DW = 16;
  localparam int FW = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N-1:0]     vld;
  logic [N*FW-1:0]  full;
  logic [N*RW-1:0]  part;
  logic [N*3-1:0]   dcode;
  logic [N*RW-1:0]  dreg;
  logic [N*DW-1:0]  wdata;
  logic [N*2-1:0]   rd_cluster;
  logic [N*RW-1:0]  rd_idx_a;
  logic [N*RW-1:0]  rd_idx_b;
  logic [N*4-1:0]   dst_mask;
  logic [N-1:0]     stall;
  logic [4*N-1:0]   wr_en;
  logic [4*N*RW-1:0] wr_idx;
  logic [4*N*DW-1:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cluster_write_router #(.NSLOT(N), .REG_W(RW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_vld(vld), .slot_full_src(full),
    .slot_part_src(part), .slot_dcode(dcode), .slot_dreg(dreg),
    .slot_wdata(wdata), .rd_cluster(rd_cluster), .rd_idx_a(rd_idx_a),
    .rd_idx_b(rd_idx_b), .dst_mask(dst_mask), .slot_stall(stall),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_slots();
    vld = '0; full = '0; part = '0; dcode = '0; dreg = '0; wdata = '0;
  endtask

  task automatic set_slot(input int s, input logic [5:0] f, input logic [3:0] p,
                          input logic [2:0] c, input logic [3:0] r,
                          input logic [15:0] d);
    vld[s] = 1'b1;
    full[s*FW +: FW] = f;
    part[s*RW +: RW] = p;
    dcode[s*3 +: 3]  = c;
    dreg[s*RW +: RW] = r;
    wdata[s*DW +: DW] = d;
  endtask

  function automatic logic [3:0] exp_mask(input int x, input int code);
    if (code < 4)  return 4'(1 << code);
    if (code == 7) return 4'hF;
    return 4'((1 << x) | (1 << ((x + code - 3) % 4)));
  endfunction

  task automatic drain();
    @(negedge clk); clear_slots();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(wr_en == '0, "R11 wr_en", 64'(wr_en), 0);
    chk(stall == '0, "R11 stall", 64'(stall), 0);
    chk(dst_mask == '0, "R11 mask", 64'(dst_mask), 0);
  endtask

  task automatic t_local_remote();
    @(negedge clk);
    set_slot(0, 6'b01_0011, 4'h5, 3'b001, 4'hC, 16'h1234);
    #1;
    chk(rd_cluster[1:0] == 2'd1, "R1 cluster", 64'(rd_cluster[1:0]), 1);
    chk(rd_idx_a[3:0] == 4'h3, "R1 idx_a", 64'(rd_idx_a[3:0]), 3);
    chk(rd_idx_b[3:0] == 4'h5, "R1 idx_b", 64'(rd_idx_b[3:0]), 5);
    chk(dst_mask[3:0] == 4'b0010, "R2 mask 001", 64'(dst_mask[3:0]), 2);
    @(negedge clk);
    chk(wr_en == 16'h0010, "R7 near en", 64'(wr_en), 64'h10);
    chk(wr_idx[4*RW +: RW] == 4'hC, "R7 near idx", 64'(wr_idx[4*RW +: RW]), 64'hC);
    chk(wr_data[4*DW +: DW] == 16'h1234, "R7 near data", 64'(wr_data[4*DW +: DW]), 64'h1234);
    set_slot(0, 6'b01_0011, 4'h5, 3'b011, 4'h2, 16'h5678);
    #1;
    chk(dst_mask[3:0] == 4'b1000, "R2 mask 011", 64'(dst_mask[3:0]), 8);
    @(negedge clk);
    chk(wr_en == '0, "R8 not at +1", 64'(wr_en), 0);
    clear_slots();
    @(negedge clk);
    chk(wr_en == 16'h1000, "R8 far en", 64'(wr_en), 64'h1000);
    chk(wr_idx[12*RW +: RW] == 4'h2, "R8 far idx", 64'(wr_idx[12*RW +: RW]), 2);
    chk(wr_data[12*DW +: DW] == 16'h5678, "R8 far data", 64'(wr_data[12*DW +: DW]), 64'h5678);
    drain();
  endtask

  task automatic t_pairs();
    for (int x = 0; x < 4; x++) begin
      for (int k = 1; k < 4; k++) begin
        @(negedge clk);
        clear_slots();
        set_slot(1, 6'(x << 4), 4'h0, 3'(3 + k), 4'(x * 3 + k), 16'h0);
        #1;
        chk(dst_mask[4 +: 4] == exp_mask(x, 3 + k), "R3 pair mask",
            64'(dst_mask[4 +: 4]), 64'(exp_mask(x, 3 + k)));
      end
    end
    drain();
  endtask

  task automatic t_bcast();
    @(negedge clk);
    set_slot(2, 6'b10_0101, 4'h1, 3'b111, 4'hA, 16'hBEEF);
    #1;
    chk(dst_mask[8 +: 4] == 4'hF, "R4 mask", 64'(dst_mask[8 +: 4]), 64'hF);
    @(negedge clk);
    chk(wr_en == 16'h0400, "R4 home lane at +1", 64'(wr_en), 64'h400);
    clear_slots();
    @(negedge clk);
    chk(wr_en == 16'h4044, "R4 remote lanes at +2", 64'(wr_en), 64'h4044);
    chk(wr_idx[14*RW +: RW] == 4'hA, "R4 idx", 64'(wr_idx[14*RW +: RW]), 64'hA);
    drain();
  endtask

  task automatic t_idle();
    @(negedge clk);
    set_slot(3, 6'b11_1111, 4'hF, 3'b111, 4'h4, 16'hAAAA);
    vld[3] = 1'b0;
    #1;
    chk(dst_mask == '0, "R5 mask", 64'(dst_mask), 0);
    chk(stall == '0, "R5 stall", 64'(stall), 0);
    @(negedge clk);
    chk(wr_en == '0, "R5 wr +1", 64'(wr_en), 0);
    @(negedge clk);
    chk(wr_en == '0, "R5 wr +2", 64'(wr_en), 0);
    drain();
  endtask

  task automatic t_waw();
    @(negedge clk);
    set_slot(0, 6'b10_0000, 4'h0, 3'b010, 4'h5, 16'h1111);
    set_slot(1, 6'b10_0001, 4'h0, 3'b010, 4'h6, 16'h2222);
    set_slot(2, 6'b00_0000, 4'h0, 3'b010, 4'h5, 16'h3333);
    #1;
    chk(stall == 4'b0100, "R6 stall younger only", 64'(stall), 4);
    @(negedge clk);
    chk(wr_en == 16'h0300, "R6 older writes", 64'(wr_en), 64'h300);
    clear_slots();
    @(negedge clk);
    chk(wr_en == '0, "R10 stalled slot silent", 64'(wr_en), 0);
    drain();
  endtask

  task automatic t_pending();
    @(negedge clk);
    set_slot(0, 6'b00_0000, 4'h0, 3'b001, 4'h3, 16'hCAFE);
    @(negedge clk);
    clear_slots();
    set_slot(0, 6'b01_0000, 4'h0, 3'b001, 4'h9, 16'h0009);
    set_slot(1, 6'b01_0000, 4'h0, 3'b001, 4'h3, 16'h0003);
    set_slot(2, 6'b01_0000, 4'h0, 3'b001, 4'h7, 16'h0007);
    #1;
    chk(stall == 4'b0011, "R9 stall vs pending remote", 64'(stall), 3);
    @(negedge clk);
    chk(wr_en == 16'h0050, "R9 lanes", 64'(wr_en), 64'h50);
    chk(wr_idx[4*RW +: RW] == 4'h3, "R9 far idx", 64'(wr_idx[4*RW +: RW]), 3);
    chk(wr_idx[6*RW +: RW] == 4'h7, "R9 near idx", 64'(wr_idx[6*RW +: RW]), 7);
    drain();
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_slots();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_local_remote();
    t_pairs();
    t_bcast();
    t_idle();
    t_waw();
    t_pending();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule